// File: doc/BRIEF.md
# Instruction Fetch Queue

This block sits between program memory and the decode stage of a processor pipeline. Program memory delivers 32-bit aligned fetch words over a valid/ready port. The queue keeps up to four of them and hands decode one opcode at a time. An opcode is either one 16-bit instruction word or two of them. A 32-bit opcode may straddle two fetch words.

Decode looks at the 16-bit word at the head of the queue through `head_word` and answers on `head_is32` whether it opens a 32-bit opcode. When `dec_req` is high and the whole opcode is present, the queue presents it and retires it at the next clock edge. When the opcode is not complete, the block raises `stall`, and the later pipeline stages freeze until more program data arrives.

The block keeps an instruction counter that holds the halfword address of the opcode at the head. The rest of the processor reads this counter as the return address on a call or an interrupt. A flush drops everything that is queued and reloads the counter with a new target. A flush is used for a branch, a call or an interrupt.

Top module: `ifq_top`

## Requirements
- R1: After a synchronous reset, `fetch_ready` is 1, `op_valid` is 0 and `ic` is 0.
- R2: The queue has four 32-bit entries. `fetch_ready` is 1 only when at least one whole entry is free. An entry whose lower half has been consumed but whose upper half has not still counts as occupied.
- R3: Within a fetch word, bits [15:0] hold the lower address and are handed out first. A 32-bit opcode is presented with its first halfword in `op_data[31:16]` and its second halfword in `op_data[15:0]`.
- R4: When `head_is32` is 0, the opcode is `{16'h0000, head}`. Once it is retired, `ic` grows by 1 at the following edge.
- R5: When `head_is32` is 1, `op_valid` stays 0 until both halfwords are queued, including when they lie in different fetch words. Retiring the opcode adds 2 to `ic`. The bench's decode model marks a head word with bit 15 set as 32-bit.
- R6: `stall` equals `dec_req` AND NOT `op_valid`. In a stalled cycle nothing is retired and `ic` holds.
- R7: When `flush` is high, `op_valid` is 0 in that same cycle and the queue is empty from the next cycle on. `ic` takes the value of `flush_target` at that edge. `stall` then follows any request until the first word at the target has arrived.
- R8: When `flush_target` is odd, the lower halfword of the first fetch word accepted after the flush is skipped. The head becomes that word's upper halfword.
- R9: A fetch word offered in the same cycle as `flush` is dropped and never reaches the head.
- R10: While `dec_req` is 0, nothing is retired, and `ic`, `op_valid` and `op_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_data | input | 32 | Fetch word, lower address in bits [15:0] |
| fetch_ready | output | 1 | A whole entry is free |
| flush | input | 1 | Program-flow discontinuity |
| flush_target | input | AW | New halfword address after a flush |
| dec_req | input | 1 | Decode asks for the next opcode |
| head_word | output | 16 | Halfword at the head, for length decode |
| head_is32 | input | 1 | Length-decode answer for `head_word` |
| op_valid | output | 1 | Complete opcode present |
| op_data | output | 32 | Opcode, zero-extended when 16-bit |
| stall | output | 1 | Request with no complete opcode |
| ic | output | AW | Halfword address of the head opcode |

## Verification
`head_word`, `op_valid`, `op_data` and `stall` are combinational from the queue state and the request, so they are due in the same cycle. `ic`, `fetch_ready` and the queue contents change at the rising edge where an opcode is retired, a word is accepted or a flush occurs, so those results are due one cycle later. The bench drives every input on a falling edge and samples one nanosecond later. Same-cycle results are read before the next rising edge. Registered results are read at the falling edge that follows that rising edge, which is one edge after the stimulus.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    localparam int HALF_W  = 16;
    localparam int FETCH_W = 32;

    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [FETCH_W-1:0] word_t;

    typedef enum logic {
        OP_SHORT = 1'b0,
        OP_LONG  = 1'b1
    } op_len_e;

    typedef struct packed {
        logic    valid;
        op_len_e len;
        word_t   data;
    } opcode_t;

    // halfwords an opcode of a given length consumes
    function automatic logic [1:0] len_halves(op_len_e len);
        return (len == OP_LONG) ? 2'd2 : 2'd1;
    endfunction

    // lower address sits in the low half of a fetch word
    function automatic half_t pick_half(word_t w, logic upper);
        return upper ? w[FETCH_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic word_t pack_opcode(half_t first, half_t second, op_len_e len);
        return (len == OP_LONG) ? {first, second} : {{HALF_W{1'b0}}, first};
    endfunction

endpackage

// File: rtl/ifq_buffer.sv
module ifq_buffer
    import ifq_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    skip_low,
    input  logic    push,
    input  word_t   push_data,
    input  logic    pop,
    input  op_len_e pop_len,
    output half_t   head0,
    output half_t   head1,
    output logic [$clog2(2*ENTRIES+1)-1:0] count,
    output logic    room
);
    localparam int EW       = $clog2(ENTRIES);
    localparam int PW       = EW + 1;
    localparam int HW_SLOTS = 2 * ENTRIES;
    localparam int CW       = $clog2(HW_SLOTS + 1);

    logic [EW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;
    logic          skip_q;
    word_t         slots [ENTRIES];

    logic          wr_en;
    logic [PW-1:0] rd_nx;
    logic [CW:0]   occ;
    logic [CW-1:0] add_n;
    logic [CW-1:0] sub_n;
    logic [PW-1:0] rd_step;

    assign wr_en = push && !flush;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        word_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && wr_q == EW'(e))
                q <= push_data;
        end
        assign slots[e] = q;
    end

    assign add_n   = wr_en ? (skip_q ? CW'(1) : CW'(2)) : '0;
    assign sub_n   = pop ? CW'(len_halves(pop_len)) : '0;
    assign rd_step = PW'(wr_en && skip_q) + (pop ? PW'(len_halves(pop_len)) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            skip_q <= 1'b0;
        end else if (flush) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            skip_q <= skip_low;
        end else begin
            cnt_q <= cnt_q + add_n - sub_n;
            rd_q  <= rd_q + rd_step;
            if (wr_en) begin
                wr_q   <= wr_q + EW'(1);
                skip_q <= 1'b0;
            end
        end
    end

    assign rd_nx = rd_q + PW'(1);
    assign head0 = pick_half(slots[rd_q[PW-1:1]], rd_q[0]);
    assign head1 = pick_half(slots[rd_nx[PW-1:1]], rd_nx[0]);
    assign count = cnt_q;

    // the dead half in front of the read pointer still occupies its entry
    assign occ  = (CW+1)'(cnt_q) + (CW+1)'(rd_q[0]);
    assign room = occ <= (CW+1)'(HW_SLOTS - 2);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= (CW+1)'(HW_SLOTS)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0)); // R7
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q >= CW'(len_halves(pop_len)))); // R5

endmodule

// File: rtl/ifq_assemble.sv
module ifq_assemble
    import ifq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          flush,
    input  logic          req,
    input  logic [CW-1:0] count,
    input  half_t         head0,
    input  half_t         head1,
    input  op_len_e       head_len,
    output opcode_t       op,
    output logic          stall,
    output logic          pop,
    output op_len_e       pop_len
);
    logic avail;

    always_comb begin
        avail = !flush && (count != '0) &&
                ((head_len == OP_SHORT) || (count >= CW'(2)));
        op.valid = avail;
        op.len   = head_len;
        op.data  = pack_opcode(head0, head1, head_len);
        pop      = req && avail;
        pop_len  = head_len;
        stall    = req && !avail;
    end

endmodule

// File: rtl/ifq_counter.sv
module ifq_counter
    import ifq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] target,
    input  logic          adv,
    input  op_len_e       adv_len,
    output logic [AW-1:0] ic
);
    logic [AW-1:0] ic_q;

    always_ff @(posedge clk) begin
        if (rst)
            ic_q <= '0;
        else if (flush)
            ic_q <= target;
        else if (adv)
            ic_q <= ic_q + AW'(len_halves(adv_len));
    end

    assign ic = ic_q;

    AST_FLUSH_IC: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ic_q == $past(target))); // R7

endmodule

// File: rtl/ifq_top.sv
module ifq_top
    import ifq_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_valid,
    input  logic [31:0]   fetch_data,
    output logic          fetch_ready,
    input  logic          flush,
    input  logic [AW-1:0] flush_target,
    input  logic          dec_req,
    output logic [15:0]   head_word,
    input  logic          head_is32,
    output logic          op_valid,
    output logic [31:0]   op_data,
    output logic          stall,
    output logic [AW-1:0] ic
);
    localparam int CW = $clog2(2 * ENTRIES + 1);

    half_t         head0;
    half_t         head1;
    logic [CW-1:0] count;
    logic          room;
    logic          pop;
    op_len_e       pop_len;
    op_len_e       head_len;
    opcode_t       op;

    assign head_len = head_is32 ? OP_LONG : OP_SHORT;

    ifq_buffer #(.ENTRIES(ENTRIES)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .skip_low  (flush_target[0]),
        .push      (fetch_valid && room),
        .push_data (fetch_data),
        .pop       (pop),
        .pop_len   (pop_len),
        .head0     (head0),
        .head1     (head1),
        .count     (count),
        .room      (room)
    );

    ifq_assemble #(.CW(CW)) u_asm (
        .flush    (flush),
        .req      (dec_req),
        .count    (count),
        .head0    (head0),
        .head1    (head1),
        .head_len (head_len),
        .op       (op),
        .stall    (stall),
        .pop      (pop),
        .pop_len  (pop_len)
    );

    ifq_counter #(.AW(AW)) u_ic (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .target  (flush_target),
        .adv     (pop),
        .adv_len (pop_len),
        .ic      (ic)
    );

    assign fetch_ready = room;
    assign head_word   = head0;
    assign op_valid    = op.valid;
    assign op_data     = op.data;

    AST_STALL_HOLDS_IC: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> $stable(ic)); // R6
    AST_IDLE_HOLDS_IC: assert property (@(posedge clk) disable iff (rst)
        (!dec_req && !flush) |=> $stable(ic)); // R10

endmodule

// File: tb/ifq_top_test.sv
module ifq_top_test;

    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_valid = 1'b0;
    logic [31:0]   fetch_data = '0;
    logic          fetch_ready;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_target = '0;
    logic          dec_req = 1'b0;
    logic [15:0]   head_word;
    logic          head_is32;
    logic          op_valid;
    logic [31:0]   op_data;
    logic          stall;
    logic [AW-1:0] ic;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // bench-side length decode: bit 15 marks a 32-bit opcode
    assign head_is32 = head_word[15];

    ifq_top #(.ENTRIES(4), .AW(AW)) uut (
        .clk          (clk),
        .rst          (rst),
        .fetch_valid  (fetch_valid),
        .fetch_data   (fetch_data),
        .fetch_ready  (fetch_ready),
        .flush        (flush),
        .flush_target (flush_target),
        .dec_req      (dec_req),
        .head_word    (head_word),
        .head_is32    (head_is32),
        .op_valid     (op_valid),
        .op_data      (op_data),
        .stall        (stall),
        .ic           (ic)
    );

    // op: 0 push, 1 retire and check, 2 check ready only
    // fields: op[42:41] data[40:9] ic[8:1] ready[0]
    localparam int NVEC = 11;
    localparam logic [42:0] VEC [NVEC] = '{
        {2'd0, 32'h8002_1001, 8'd0, 1'b1},
        {2'd0, 32'h2004_0003, 8'd0, 1'b1},
        {2'd0, 32'h0006_9005, 8'd0, 1'b1},
        {2'd0, 32'h4008_3007, 8'd0, 1'b1},
        {2'd2, 32'h0000_0000, 8'd0, 1'b0},
        {2'd1, 32'h0000_1001, 8'd0, 1'b0},
        {2'd1, 32'h8002_0003, 8'd1, 1'b1},
        {2'd1, 32'h0000_2004, 8'd3, 1'b1},
        {2'd1, 32'h9005_0006, 8'd4, 1'b1},
        {2'd1, 32'h0000_3007, 8'd6, 1'b1},
        {2'd1, 32'h0000_4008, 8'd7, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_data  = w;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic retire(input string tag, input logic [31:0] exp_op, input logic [31:0] exp_ic);
        @(negedge clk);
        dec_req = 1'b1;
        #1;
        chk({tag, " op_valid"}, 32'(op_valid), 32'd1);
        chk({tag, " op_data"}, op_data, exp_op);
        chk({tag, " ic"}, 32'(ic), exp_ic);
        @(negedge clk);
        dec_req = 1'b0;
    endtask

    task automatic do_flush(input logic [AW-1:0] tgt, input logic fv, input logic [31:0] w);
        @(negedge clk);
        flush        = 1'b1;
        flush_target = tgt;
        fetch_valid  = fv;
        fetch_data   = w;
        dec_req      = 1'b1;
        #1;
        chk("R7 op_valid in flush cycle", 32'(op_valid), 32'd0);
        chk("R7 stall in flush cycle", 32'(stall), 32'd1);
        @(negedge clk);
        flush       = 1'b0;
        fetch_valid = 1'b0;
        dec_req     = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 fetch_ready", 32'(fetch_ready), 32'd1);
        chk("R1 op_valid", 32'(op_valid), 32'd0);
        chk("R1 ic", 32'(ic), 32'd0);

        // R6: request on empty queue stalls and holds ic
        @(negedge clk);
        dec_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R6 stall on empty", 32'(stall), 32'd1);
        chk("R6 ic held", 32'(ic), 32'd0);
        @(negedge clk);
        dec_req = 1'b0;

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            logic [42:0] v;
            v = VEC[i];
            case (v[42:41])
                2'd0: begin
                    @(negedge clk);
                    #1;
                    chk("R2 ready before push", 32'(fetch_ready), 32'(v[0]));
                    fetch_valid = 1'b1;
                    fetch_data  = v[40:9];
                    @(negedge clk);
                    fetch_valid = 1'b0;
                end
                2'd1: begin
                    retire("R3 R4 R5 table", v[40:9], 32'(v[8:1]));
                    #1;
                    chk("R2 ready after retire", 32'(fetch_ready), 32'(v[0]));
                end
                default: begin
                    @(negedge clk);
                    #1;
                    chk("R2 ready when full", 32'(fetch_ready), 32'(v[0]));
                end
            endcase
        end

        // R5: 32-bit opcode split over two fetch words
        do_flush(AW'('h40), 1'b0, 32'h0);
        #1;
        chk("R7 ic after flush", 32'(ic), 32'h40);
        chk("R7 empty after flush", 32'(op_valid), 32'd0);
        push_word(32'hA111_0111);
        retire("R4 short", 32'h0000_0111, 32'h40);
        @(negedge clk);
        dec_req = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R5 half missing no op", 32'(op_valid), 32'd0);
        chk("R6 stall half missing", 32'(stall), 32'd1);
        chk("R6 ic held half missing", 32'(ic), 32'h41);
        dec_req = 1'b0;
        push_word(32'h5555_0222);
        retire("R5 long across entries", 32'hA111_0222, 32'h41);
        retire("R4 after long", 32'h0000_5555, 32'h43);

        // R7: flush discards queued words
        push_word(32'h1111_2222);
        push_word(32'h3333_4444);
        do_flush(AW'('h80), 1'b0, 32'h0);
        @(negedge clk);
        dec_req = 1'b1;
        #1;
        chk("R7 discarded op_valid", 32'(op_valid), 32'd0);
        chk("R7 stall until target word", 32'(stall), 32'd1);
        chk("R7 ic target", 32'(ic), 32'h80);
        chk("R7 ready after flush", 32'(fetch_ready), 32'd1);
        @(negedge clk);
        dec_req = 1'b0;

        // R8: odd target skips the low halfword
        do_flush(AW'('h101), 1'b0, 32'h0);
        push_word(32'h1234_DEAD);
        retire("R8 odd target", 32'h0000_1234, 32'h101);

        // R9: fetch word with flush is dropped
        do_flush(AW'('h200), 1'b1, 32'h7777_6666);
        @(negedge clk);
        dec_req = 1'b1;
        #1;
        chk("R9 dropped word", 32'(op_valid), 32'd0);
        @(negedge clk);
        dec_req = 1'b0;
        push_word(32'h0ABC_0DEF);
        retire("R9 head is new word", 32'h0000_0DEF, 32'h200);

        // R10: no request, nothing retired
        repeat (3) @(negedge clk);
        #1;
        chk("R10 ic held", 32'(ic), 32'h201);
        chk("R10 op_valid held", 32'(op_valid), 32'd1);
        chk("R10 op_data held", op_data, 32'h0000_0ABC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule